// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged FIFO

This block turns an asynchronous serial line into a stream of characters. A free-running 16x oversampling tick paces a small frame engine. The engine confirms each start bit at the middle of its bit time, so a short low glitch never starts a character. It then takes one mid-bit sample for every data bit, for the optional parity bit and for the stop bit. Data arrives least significant bit first. The line format is set by static configuration pins that match the far-end transmitter. The configuration must not change while a frame is in flight.

Every finished frame is written into a 16-entry queue. Each entry carries three flags: parity error, framing error and break. The host drains the queue through a valid/ready port. `rd_valid` is high whenever the queue holds an entry. The head entry is removed on a clock edge where `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, the head entry and its flags stay unchanged. The serial line cannot be stalled, so back-pressure is absorbed by the queue. A frame that completes while the queue is full is lost and raises a sticky overrun flag.

The receiver also drives a request-to-send output for flow control. When automatic control is enabled, the output drops once the fill level reaches a selectable threshold. It rises again only after the queue has drained to empty.

Top module: `serrx_top`

## Requirements
- R1: `cfg_wlen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The bits are received least significant bit first, and the stored byte is zero-extended.
- R2: With `cfg_par_en` high, one parity bit follows the data bits. `cfg_par_odd` selects odd (1) or even (0) parity. A mismatch sets the entry's `rd_perr`.
- R3: A stop bit sampled low sets `rd_ferr`. The received data bits are still stored.
- R4: A low pulse on `rxd` shorter than half a bit time stores nothing. The next valid frame is received normally.
- R5: A frame whose data, parity and stop samples are all low stores exactly one entry: data 0, `rd_brk`=1, `rd_ferr`=1, `rd_perr`=0. Nothing further is stored until the line has returned high.
- R6: The queue returns entries in arrival order, each with its own flags. The head entry stays stable while `rd_valid` is high and `rd_ready` is low.
- R7: `fifo_level` reports the number of stored entries, from 0 to 16.
- R8: A frame that completes while 16 entries are held is discarded, and the stored entries are kept. `overrun` then rises and stays high until a one-cycle `ovr_ack` pulse clears it.
- R9: `rts_thr_sel` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 14 entries. With `rts_auto_en` high, `rts_on` goes low once the level reaches the threshold. It returns high only after the level has been 0.
- R10: With `rts_auto_en` low, `rts_on` is high whatever the level.
- R11: After reset: `rd_valid`=0, `fifo_level`=0, `overrun`=0 and `rts_on`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| cfg_wlen | input | 2 | Data-bit count code (5 + code) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rts_auto_en | input | 1 | Enable automatic flow control |
| rts_thr_sel | input | 2 | Threshold code: 1, 4, 8 or 14 entries |
| rd_valid | output | 1 | Queue holds an entry |
| rd_ready | input | 1 | Host takes the head entry |
| rd_data | output | DATA_W | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| fifo_level | output | $clog2(DEPTH+1) | Stored entry count |
| overrun | output | 1 | Sticky overrun flag |
| ovr_ack | input | 1 | Clears overrun |
| rts_on | output | 1 | Request-to-send, high = send allowed |

## Verification
The bench sends frames in three formats: 8 data bits with no parity, 7 data bits with even parity and 5 data bits with odd parity. It deliberately corrupts the parity and stop bits. A design that sampled at bit edges, or shifted bits in the wrong order, would mismatch the scoreboard. A half-bit glitch is sent to catch a receiver that starts on any falling edge, which would store a spurious 0xFF-style entry. A long low line checks that exactly one break entry appears rather than a run of zero characters. Filling the queue past 16 entries checks that an overrun overwrites nothing and that the flag is sticky. The flow-control threshold and its hysteresis are checked by watching `rts_on` around the fourth entry, during the drain, and with the single-entry threshold.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_err_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRKW
  } rx_st_e;

  localparam int MIN_BITS = 5;

  function automatic int thr_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/serrx_framer.sv
module serrx_framer
  import serrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              chr_valid,
  output logic [DATA_W-1:0] chr_data,
  output rx_err_t           chr_err
);

  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int MID = OSR / 2 - 1;

  // input synchronizer, reset to idle level
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= rxd;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign rx_s = sync_q[SYNC_STAGES-1];

  rx_st_e            st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh;
  logic              px;
  logic              any1;
  logic              perr_q;

  logic [BW-1:0]     nbits;
  logic [BW-1:0]     sh_amt;
  logic              stop_brk;
  logic [DATA_W-1:0] aligned;

  assign nbits    = BW'(MIN_BITS) + BW'(wlen);
  assign sh_amt   = BW'(DATA_W) - nbits;
  assign aligned  = sh >> sh_amt;
  assign stop_brk = !rx_s && !any1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      sh        <= '0;
      px        <= 1'b0;
      any1      <= 1'b0;
      perr_q    <= 1'b0;
      chr_valid <= 1'b0;
      chr_data  <= '0;
      chr_err   <= '0;
    end else begin
      chr_valid <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: begin
            if (!rx_s) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == CW'(MID)) begin
              cnt <= '0;
              if (rx_s) begin
                st <= S_IDLE;
              end else begin
                st     <= S_DATA;
                bitn   <= '0;
                px     <= 1'b0;
                any1   <= 1'b0;
                perr_q <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt  <= '0;
              sh   <= {rx_s, sh[DATA_W-1:1]};
              px   <= px ^ rx_s;
              any1 <= any1 | rx_s;
              bitn <= bitn + 1'b1;
              if (bitn == nbits - 1'b1) st <= par_en ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt    <= '0;
              perr_q <= ((px ^ rx_s) != par_odd);
              any1   <= any1 | rx_s;
              st     <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt          <= '0;
              chr_valid    <= 1'b1;
              chr_data     <= stop_brk ? '0 : aligned;
              chr_err.brk  <= stop_brk;
              chr_err.ferr <= !rx_s;
              chr_err.perr <= perr_q && !stop_brk;
              st           <= stop_brk ? S_BRKW : S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_BRKW: begin
            if (rx_s) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R5: a break entry is all zero and carries a framing error
  a_r5_break_entry: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid && chr_err.brk |-> chr_data == '0 && chr_err.ferr && !chr_err.perr);

  // R5: after a break nothing is written until the line is seen high
  a_r5_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_BRKW && !rx_s |=> !chr_valid);

  // R4: a write only follows a sampling tick
  a_r4_write_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> $past(tick));

endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          overrun,
  input  logic          ovr_ack
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full, push, pop;

  assign full     = (level == LW'(DEPTH));
  assign rd_valid = (level != '0);
  assign push     = wr_en && !full;
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_en && full) overrun <= 1'b1;
      else if (ovr_ack)  overrun <= 1'b0;
    end
  end

  // R7: level never exceeds depth
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R6: head entry held under back-pressure
  a_r6_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R8: a write into a full queue changes nothing and raises overrun
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && full && !rd_ready |=> level == LW'(DEPTH) && overrun && $stable(rd_data));

  // R8: overrun is sticky until acknowledged
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_ack |=> overrun);

endmodule

// File: rtl/serrx_rts.sv
module serrx_rts
  import serrx_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] lvl,
  input  logic [1:0]    thr_sel,
  input  logic          auto_en,
  output logic          rts_on
);

  logic [LW-1:0] thr;
  logic          hold_q;

  assign thr = LW'(thr_decode(thr_sel));

  // hysteresis: assert hold at threshold, release only when empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hold_q <= 1'b0;
    else if (lvl == '0)   hold_q <= 1'b0;
    else if (lvl >= thr)  hold_q <= 1'b1;
  end

  assign rts_on = !(auto_en && hold_q);

  // R9: hold only rises after the level reached the threshold
  a_r9_rise_at_thr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> $past(lvl) >= $past(thr));

  // R9: a queue that stayed empty leaves rts on
  a_r9_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
    lvl == '0 && $past(lvl) == '0 |-> rts_on);

endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LW         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rts_auto_en,
  input  logic [1:0]        rts_thr_sel,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_perr,
  output logic              rd_ferr,
  output logic              rd_brk,
  output logic [LW-1:0]     fifo_level,
  output logic              overrun,
  input  logic              ovr_ack,
  output logic              rts_on
);

  localparam int EW = DATA_W + 3;

  logic              chr_valid;
  logic [DATA_W-1:0] chr_data;
  rx_err_t           chr_err;
  logic [EW-1:0]     head;

  serrx_framer #(
    .DATA_W     (DATA_W),
    .OSR        (OSR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .rxd      (rxd),
    .wlen     (cfg_wlen),
    .par_en   (cfg_par_en),
    .par_odd  (cfg_par_odd),
    .chr_valid(chr_valid),
    .chr_data (chr_data),
    .chr_err  (chr_err)
  );

  serrx_fifo #(
    .W    (EW),
    .DEPTH(DEPTH),
    .LW   (LW)
  ) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (chr_valid),
    .wr_data ({chr_err, chr_data}),
    .rd_valid(rd_valid),
    .rd_ready(rd_ready),
    .rd_data (head),
    .level   (fifo_level),
    .overrun (overrun),
    .ovr_ack (ovr_ack)
  );

  assign rd_data = head[DATA_W-1:0];
  assign rd_perr = head[DATA_W];
  assign rd_ferr = head[DATA_W+1];
  assign rd_brk  = head[DATA_W+2];

  serrx_rts #(
    .LW(LW)
  ) u_rts (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (fifo_level),
    .thr_sel(rts_thr_sel),
    .auto_en(rts_auto_en),
    .rts_on (rts_on)
  );

  // R10: without automatic control rts is always on
  a_r10_manual_on: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |-> rts_on);

endmodule

// File: tb/serrx_top_bench.sv
module serrx_top_bench;

  localparam int TICKDIV = 4;
  localparam int BITCLK  = 16 * TICKDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rts_auto_en = 1'b0;
  logic [1:0] rts_thr_sel = 2'd1;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk;
  logic [4:0] fifo_level;
  logic       overrun;
  logic       ovr_ack = 1'b0;
  logic       rts_on;

  int total = 0;
  int bad   = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  tcnt = '0;

  always #2.5 clk = ~clk;

  always @(posedge clk) tcnt <= tcnt + 1'b1;
  assign tick16 = (tcnt == 2'd3);

  serrx_top u_serrx_top (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rts_auto_en(rts_auto_en), .rts_thr_sel(rts_thr_sel),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .fifo_level(fifo_level), .overrun(overrun), .ovr_ack(ovr_ack),
    .rts_on(rts_on)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every popped entry with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6 unexpected entry act=%0h exp=none",
                 {rd_brk, rd_ferr, rd_perr, rd_data});
      end else begin
        logic [10:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rd_brk, rd_ferr, rd_perr, rd_data} !== e) begin
          bad++;
          $display("FAIL %s entry act=%0h exp=%0h", t,
                   {rd_brk, rd_ferr, rd_perr, rd_data}, e);
        end
      end
    end
  end

  // driver: one frame on rxd, expected entry into the scoreboard
  task automatic send_frame(input logic [7:0] d, input logic bad_par,
                            input logic stop_v, input logic expect_it, input string tag);
    int          nb;
    logic [7:0]  m;
    logic        pb;
    nb = 5 + int'(cfg_wlen);
    m  = d & ((8'd1 << nb) - 8'd1);
    pb = (^m) ^ cfg_par_odd ^ bad_par;
    if (expect_it) begin
      exp_q.push_back({1'b0, !stop_v, cfg_par_en & bad_par, m});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      rxd = m[b];
      repeat (BITCLK) @(negedge clk);
    end
    if (cfg_par_en) begin
      rxd = pb;
      repeat (BITCLK) @(negedge clk);
    end
    rxd = stop_v;
    repeat (stop_v ? BITCLK : 40) @(negedge clk);
    rxd = 1'b1;
    repeat (stop_v ? 16 : BITCLK + 16) @(negedge clk);
  endtask

  task automatic drain();
    rd_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 rd_valid", rd_valid, 0);
    chk("R11 level", fifo_level, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 rts_on", rts_on, 1);

    rd_ready = 1'b1;
    // R1: 8 data bits, no parity
    send_frame(8'hA5, 0, 1, 1, "R1 8N1");
    send_frame(8'h3C, 0, 1, 1, "R1 8N1");
    send_frame(8'h00, 0, 1, 1, "R1 8N1 zero");
    send_frame(8'hFF, 0, 1, 1, "R1 8N1 ones");
    // R2: 7 data bits even parity
    cfg_wlen = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_frame(8'h5A, 0, 1, 1, "R2 7E1 good");
    send_frame(8'h33, 1, 1, 1, "R2 7E1 bad");
    // R1/R2: 5 data bits odd parity
    cfg_wlen = 2'd0; cfg_par_odd = 1'b1;
    send_frame(8'hFF, 0, 1, 1, "R1 5O1 mask");
    send_frame(8'h0A, 1, 1, 1, "R2 5O1 bad");
    // R3: framing error
    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    send_frame(8'h81, 0, 0, 1, "R3 framing");
    drain();
    chk("R7 level drained", fifo_level, 0);

    // R4: glitch shorter than half a bit
    rd_ready = 1'b0;
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk("R4 glitch valid", rd_valid, 0);
    chk("R4 glitch level", fifo_level, 0);
    send_frame(8'h6E, 0, 1, 1, "R4 after glitch");
    chk("R4 after glitch level", fifo_level, 1);
    drain();

    // R5: long break
    rd_ready = 1'b0;
    rxd = 1'b0;
    repeat (20 * BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITCLK) @(negedge clk);
    chk("R5 single break entry", fifo_level, 1);
    exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
    tag_q.push_back("R5 break entry");
    drain();

    // R8/R9: fill with flow control at threshold 4
    rd_ready = 1'b0;
    rts_auto_en = 1'b1;
    rts_thr_sel = 2'd1;
    for (int i = 0; i < 16; i++) begin
      send_frame(8'(i * 7 + 1), 0, 1, 1, "R6 order");
      if (i == 2) chk("R9 below thr", rts_on, 1);
      if (i == 3) chk("R9 at thr", rts_on, 0);
    end
    chk("R7 full level", fifo_level, 16);
    chk("R6 head held", rd_data, 8'h01);
    chk("R8 no overrun yet", overrun, 0);
    send_frame(8'hEE, 0, 1, 0, "R8 dropped");
    chk("R8 overrun set", overrun, 1);
    chk("R8 level kept", fifo_level, 16);
    chk("R8 head kept", rd_data, 8'h01);
    rts_auto_en = 1'b0;
    @(negedge clk);
    chk("R10 manual on", rts_on, 1);
    rts_auto_en = 1'b1;
    @(negedge clk);
    chk("R9 hold kept", rts_on, 0);
    drain();
    chk("R7 empty", fifo_level, 0);
    chk("R9 released", rts_on, 1);
    chk("R8 still set", overrun, 1);
    ovr_ack = 1'b1;
    @(negedge clk);
    ovr_ack = 1'b0;
    @(negedge clk);
    chk("R8 cleared", overrun, 0);

    // R9: threshold of one entry
    rd_ready = 1'b0;
    rts_thr_sel = 2'd0;
    send_frame(8'h42, 0, 1, 1, "R9 thr1 data");
    chk("R9 thr1", rts_on, 0);
    drain();
    chk("R9 thr1 release", rts_on, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule